// File: doc/BRIEF.md
# UART Modem Status Register

This block is the modem status register of a UART, read by the host. It watches four modem control inputs that are active low at the pins: clear-to-send (CTS), data-set-ready (DSR), ring indicator (RI) and carrier detect (CD). Each pin passes through a synchroniser. The upper nibble of the register shows the inverted pin levels, so a 1 means the line is asserted. The lower nibble holds sticky change flags, and a host read clears them.

DSR, RI and CD share their pins with general-purpose I/O. These three lines reach the register only while the modem-mode select input is high. CTS is a dedicated input and is always live. An interrupt request output is raised while any visible change flag is set and the interrupt enable input is high.

The host reads `msr_q` in the cycle it pulses `rd_stb`. The flags are cleared on the clock edge that ends that cycle. A change detected on that same edge is kept, so no event is lost.

Top module: `modem_status_reg`

## Requirements
- R1: After a synchronous reset with all pins high (inactive), `msr_q` reads 8'h00 and `irq` is 0.
- R2: Bits 7, 6, 5 and 4 of `msr_q` hold the complement of `cd_n`, `ri_n`, `dsr_n` and `cts_n`, in that order. A pin change shows up after the second rising edge that follows it.
- R3: Bits 0 (CTS), 1 (DSR) and 3 (CD) set when their line changes in either direction. A flag sets one edge after its status bit changes.
- R4: Bit 2 (RI) sets only when the RI status bit goes from 0 to 1, which is a falling edge on `ri_n`. A rising edge on `ri_n` leaves bit 2 unchanged.
- R5: On the edge that ends a cycle with `rd_stb` high, every change flag clears.
- R6: If a change is detected on the same edge as a clearing read, the flag for that line stays set.
- R7: While `mdm_sel` is 0, bits 7, 6, 5, 3, 2 and 1 read 0, and the DSR, RI and CD flags do not set and keep no value. CTS (bits 4 and 0) works as usual. Raising `mdm_sel` while the pins are steady sets no flag.
- R8: `irq` is 1 exactly when `irq_en` is 1 and at least one of bits 3 to 0 of `msr_q` is 1.
- R9: A change flag stays set after its line returns to its former level, until a read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low, shared with GPIO |
| ri_n | input | 1 | Ring indicator pin, active low, shared with GPIO |
| cd_n | input | 1 | Carrier detect pin, active low, shared with GPIO |
| mdm_sel | input | 1 | 1 routes the shared pins to the register (modem mode) |
| rd_stb | input | 1 | Host read strobe; clears the change flags |
| irq_en | input | 1 | Modem-status interrupt enable |
| msr_q | output | 8 | Register value: status in bits 7..4, change flags in bits 3..0 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default two-stage synchroniser. This gives a fixed latency: two edges from a pin change to the status bit and three edges to the flag. That makes it possible to land a host read exactly on the edge that detects a change, and so to test the rule that the flag is kept. The same fixed latency lets the bench check the RI edge direction and switch modem mode while lines are held, each with literal expected values. Random traffic then compares every cycle against a model built from the requirements.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int N_LINES = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_CD  = 3;

  function automatic bit line_is_shared(input int idx);
    return idx != IDX_CTS;
  endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/msr_delta_flag.sv
module msr_delta_flag #(
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic enable,
  input  logic clear,
  output logic flag
);
  logic prev_q;
  logic flag_q;
  logic chg;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_s;
  end

  generate
    if (RISE_ONLY) begin : g_rise
      assign chg = prev_q & ~pin_s;
    end else begin : g_any
      assign chg = prev_q ^ pin_s;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (!enable) flag_q <= 1'b0;
    else if (chg)     flag_q <= 1'b1;
    else if (clear)   flag_q <= 1'b0;
  end

  assign flag = flag_q;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_set_has_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $rose(flag_q)) |-> ($past(chg) && $past(enable)));

  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    (clear && !chg) |=> !flag_q);

  p_keep_on_hit_r6: assert property (@(posedge clk) disable iff (rst)
    (clear && chg && enable) |=> flag_q);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clear && enable) |=> flag_q);

  generate
    if (RISE_ONLY) begin : g_rise_chk
      p_rise_only_r4: assert property (@(posedge clk) disable iff (rst)
        (prev_q == 1'b0 && pin_s == 1'b1 && !flag_q) |=> !flag_q);
    end
  endgenerate
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       cd_n,
  input  logic       mdm_sel,
  input  logic       rd_stb,
  input  logic       irq_en,
  output logic [7:0] msr_q,
  output logic       irq
);
  localparam int MSR_W = 2 * N_LINES;

  logic [N_LINES-1:0] pin_raw;
  logic [N_LINES-1:0] pin_s;
  logic [N_LINES-1:0] line_on;
  logic [N_LINES-1:0] flag;
  logic [N_LINES-1:0] status;
  logic [N_LINES-1:0] flag_vis;

  assign pin_raw[IDX_CTS] = cts_n;
  assign pin_raw[IDX_DSR] = dsr_n;
  assign pin_raw[IDX_RI]  = ri_n;
  assign pin_raw[IDX_CD]  = cd_n;

  msr_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (pin_s)
  );

  genvar i;
  generate
    for (i = 0; i < N_LINES; i++) begin : g_line
      if (line_is_shared(i)) begin : g_shared
        assign line_on[i] = mdm_sel;
      end else begin : g_dedicated
        assign line_on[i] = 1'b1;
      end

      msr_delta_flag #(.RISE_ONLY(i == IDX_RI)) u_flag (
        .clk    (clk),
        .rst    (rst),
        .pin_s  (pin_s[i]),
        .enable (line_on[i]),
        .clear  (rd_stb),
        .flag   (flag[i])
      );
    end
  endgenerate

  assign status   = ~pin_s & line_on;
  assign flag_vis = flag & line_on;
  assign msr_q    = MSR_W'({status, flag_vis});
  assign irq      = irq_en & (|flag_vis);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= 2'd0;
    else if (age != 3) age <= age + 2'd1;
  end

  p_gated_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !mdm_sel |-> (msr_q[7:5] == 3'b000 && msr_q[3:1] == 3'b000));

  p_irq_match_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_en && msr_q[3:0] != 4'h0));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> msr_q[3:0] == 4'h0);

  generate
    if (SYNC_STAGES == 2) begin : g_lat_chk
      p_cts_status_r2: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> msr_q[4] == !$past(cts_n, 2));
    end
  endgenerate
endmodule

// File: tb/sim_modem_status_reg.sv
`timescale 1ns/1ps
module sim_modem_status_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
  logic mdm_sel = 1'b1, rd_stb = 1'b0, irq_en = 1'b1;
  logic [7:0] msr_q;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // model state; pin vector order {cd, ri, dsr, cts}
  logic [3:0] m_s1 = 4'hF, m_s2 = 4'hF, m_prev = 4'hF, m_flag = 4'h0;

  always #5 clk = ~clk;

  modem_status_reg u0 (
    .clk(clk), .rst(rst), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
    .mdm_sel(mdm_sel), .rd_stb(rd_stb), .irq_en(irq_en), .msr_q(msr_q), .irq(irq)
  );

  function automatic logic [3:0] vis_mask(input logic en);
    return en ? 4'hF : 4'h1;
  endfunction

  function automatic logic [7:0] exp_msr(input logic [3:0] s2, input logic [3:0] fl, input logic en);
    return {~s2 & vis_mask(en), fl & vis_mask(en)};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic [3:0] pins);
    if (rst) begin
      m_s1 = 4'hF; m_s2 = 4'hF; m_prev = 4'hF; m_flag = 4'h0;
    end else begin
      for (int k = 0; k < 4; k++) begin
        logic chg;
        chg = (k == 2) ? (m_prev[k] & ~m_s2[k]) : (m_prev[k] ^ m_s2[k]);
        if (k != 0 && !mdm_sel) m_flag[k] = 1'b0;
        else if (chg)           m_flag[k] = 1'b1;
        else if (rd_stb)        m_flag[k] = 1'b0;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  endtask

  // drive at negedge, one edge, return at next negedge
  task automatic cyc(input logic [3:0] pins, input logic en, input logic rd, input logic ie);
    {cd_n, ri_n, dsr_n, cts_n} = pins;
    mdm_sel = en; rd_stb = rd; irq_en = ie;
    @(posedge clk);
    model_edge(pins);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic hold(input logic [3:0] pins, input logic en, input int n);
    for (int k = 0; k < n; k++) cyc(pins, en, 1'b0, irq_en);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    cyc(4'hF, 1'b1, 1'b0, 1'b1);
    cyc(4'hF, 1'b1, 1'b0, 1'b1);
    rst = 1'b0;
    chk("R1 reset msr", msr_q, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);

    // CTS low: status after 2 edges, flag after 3
    cyc(4'hE, 1'b1, 1'b0, 1'b1);
    chk("R2 not yet visible", msr_q, 8'h00);
    cyc(4'hE, 1'b1, 1'b0, 1'b1);
    chk("R2 cts status", msr_q, 8'h10);
    cyc(4'hE, 1'b1, 1'b0, 1'b1);
    chk("R3 cts flag", msr_q, 8'h11);
    chk("R8 irq on flag", {7'b0, irq}, 8'h01);

    hold(4'hF, 1'b1, 3);
    chk("R9 cts flag sticky", msr_q, 8'h01);
    cyc(4'hF, 1'b1, 1'b1, 1'b1);
    chk("R5 read clears", msr_q, 8'h00);
    chk("R8 irq drops", {7'b0, irq}, 8'h00);

    // RI falling pin => status rise => flag
    hold(4'hB, 1'b1, 3);
    chk("R4 ri flag on assert", msr_q, 8'h44);
    cyc(4'hB, 1'b1, 1'b1, 1'b1);
    chk("R5 ri cleared", msr_q, 8'h40);
    hold(4'hF, 1'b1, 4);
    chk("R4 ri release no flag", msr_q, 8'h00);

    // DSR change detected on the read edge
    hold(4'hD, 1'b1, 2);
    chk("R2 dsr status", msr_q, 8'h20);
    cyc(4'hD, 1'b1, 1'b1, 1'b1);
    chk("R6 flag kept on coincident read", msr_q, 8'h22);
    cyc(4'hD, 1'b1, 1'b1, 1'b1);
    chk("R5 dsr cleared", msr_q, 8'h20);

    // modem mode off
    cyc(4'hD, 1'b0, 1'b0, 1'b1);
    chk("R7 shared status hidden", msr_q, 8'h00);
    hold(4'h5, 1'b0, 3);
    chk("R7 cd ignored when off", msr_q, 8'h00);
    chk("R7 no irq when off", {7'b0, irq}, 8'h00);
    hold(4'h4, 1'b0, 3);
    chk("R7 cts still live", msr_q, 8'h11);
    cyc(4'h4, 1'b0, 1'b1, 1'b1);
    chk("R5 cts cleared while off", msr_q, 8'h10);
    cyc(4'h4, 1'b1, 1'b0, 1'b1);
    chk("R7 re-enable no spurious flag", msr_q, 8'hB0);
    cyc(4'h4, 1'b1, 1'b0, 1'b1);
    chk("R7 re-enable steady", msr_q, 8'hB0);

    // interrupt enable gating
    hold(4'h5, 1'b1, 3);
    chk("R3 cts release flag", msr_q, 8'hA1);
    cyc(4'h5, 1'b1, 1'b0, 1'b0);
    chk("R8 irq masked", {7'b0, irq}, 8'h00);
    cyc(4'h5, 1'b1, 1'b0, 1'b1);
    chk("R8 irq unmasked", {7'b0, irq}, 8'h01);

    // random traffic against the model
    for (int t = 0; t < 4000; t++) begin
      logic [3:0] pins;
      logic en, rd, ie;
      pins = {cd_n, ri_n, dsr_n, cts_n};
      for (int k = 0; k < 4; k++) if ($urandom_range(0, 5) == 0) pins[k] = ~pins[k];
      en = ($urandom_range(0, 15) != 0) ? mdm_sel : ~mdm_sel;
      rd = ($urandom_range(0, 3) == 0);
      ie = ($urandom_range(0, 7) != 0);
      if (t == 2000) rst = 1'b1;
      if (t == 2002) rst = 1'b0;
      cyc(pins, en, rd, ie);
      if (!rst) begin
        chk("R2 random status", {msr_q[7:4], 4'h0}, {exp_msr(m_s2, m_flag, mdm_sel) & 8'hF0});
        chk("R3 random flags", {4'h0, msr_q[3:0]}, {exp_msr(m_s2, m_flag, mdm_sel) & 8'h0F});
        chk("R8 random irq", {7'b0, irq},
            {7'b0, irq_en & (|(m_flag & vis_mask(mdm_sel)))});
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule